// File: doc/BRIEF.md
# Multi-Period ADC Trigger Scheduler

This block plans the analog sampling of a three-phase converter control loop. Each control tick (nominally 20 kHz, whatever PWM frequency is chosen) opens a sampling window spanning three PWM periods. In every one of those periods, one ADC burst of three conversions is started when the free-running PWM counter matches a programmable compare value. The three conversions are one phase current, one line-to-line voltage and the DC bus voltage. After the third period the scheduler stays silent until the next tick.

Conversion results arrive with an end-of-conversion strobe. They are written into a working bank of seven 12-bit entries. On the next control tick the working bank is copied into the output bank, so the control algorithm always uses data gathered during the previous control period. A valid flag marks a complete bank. A sticky overrun flag records any tick that arrived before its sampling window had finished. Keeping the window to three PWM periods is the reason the PWM rate must be at least three times the control rate.

Top module: `adc_trig_sched`

## Requirements
- R1: After reset `adcTrig`, `bankValid`, `overrun` and every output bank entry are 0.
- R2: While a window is open, fewer than three periods are done and no conversion is outstanding, a cycle with `pwmCnt == cmpVal` (and no tick) makes `adcTrig` pulse in the following cycle. This starts the period's first conversion.
- R3: In period k (k = 0, 1, 2) of a window, the three conversions use `chanSel` codes k, 3+k and 6 in that order. Codes 0/1/2 are phase currents A/B/C, codes 3/4/5 are line voltages AB/BC/CA, and code 6 is the DC bus.
- R4: The second and third conversions of a period are triggered in the cycle after the end-of-conversion of the preceding one. No trigger is issued while a conversion is outstanding.
- R5: Once three periods are complete, no trigger is issued until the next `ctrlTick`. A tick restarts the window at period 0 and drops any conversion in flight. A tick takes precedence over a compare match or an `eocValid` in the same cycle.
- R6: `eocData` is stored at the bank index equal to the `chanSel` of the outstanding conversion. The whole working bank appears on `bankOut` (entry i at bits 12i+11:12i) in the cycle after a tick and is held until the next tick.
- R7: On each tick `bankValid` is loaded with 1 only if the window opened by the previous tick completed all three periods. On the first tick after reset it is loaded with 0.
- R8: A tick that ends an incomplete window (any tick except the first after reset) sets `overrun`, which stays 1 until reset.
- R9: An `eocValid` with no conversion outstanding changes no bank entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwmCnt | input | 16 | PWM carrier counter value |
| cmpVal | input | 16 | Counter value at which a period's burst starts |
| ctrlTick | input | 1 | Control-period tick, one cycle wide |
| eocValid | input | 1 | ADC end-of-conversion strobe |
| eocData | input | 12 | ADC result qualified by `eocValid` |
| adcTrig | output | 1 | One-cycle start-of-conversion pulse |
| chanSel | output | 3 | Mux channel of the conversion being started |
| bankOut | output | 84 | Previous control period's seven results, entry i at bits 12i+11:12i |
| bankValid | output | 1 | Output bank holds a complete window |
| overrun | output | 1 | Sticky: a tick cut a window short |

## Verification
The assertions assume the ADC answers each trigger at least one cycle later, so a trigger is always a single-cycle pulse. They also assume `ctrlTick` is one cycle wide. The bench's responder answers after a fixed three-cycle latency, and the bench drives the tick as an isolated pulse. Tick intervals are varied: long enough for full windows, too short so windows are cut and overrun sets, and coincident with result strobes. Stray result strobes are injected only while no conversion is outstanding, which is the condition R9 addresses.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;
  // strobes from sequencer to datapath
  typedef struct packed {
    logic wrEn;       // store eocData at chanSel
    logic swap;       // copy working bank to output
    logic swapValid;  // the closing window was complete
    logic ovrSet;     // the closing window was cut short
  } schedStrobe_t;
endpackage

// File: rtl/adc_sched_ctrl.sv
module adc_sched_ctrl
  import adc_sched_pkg::*;
#(
  parameter int NPH = 3,
  parameter int CW  = 16,
  parameter int SW  = $clog2(2*NPH+1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] pwmCnt,
  input  logic [CW-1:0] cmpVal,
  input  logic          ctrlTick,
  input  logic          eocValid,
  output logic          adcTrig,
  output logic [SW-1:0] chanSel,
  output schedStrobe_t  strobe
);
  localparam int PW = $clog2(NPH+1);
  localparam logic [PW-1:0] PER_DONE = PW'(NPH);
  localparam logic [SW-1:0] SEL_BUS  = SW'(2*NPH);

  logic          active;
  logic          busy;
  logic [PW-1:0] perCnt;
  logic [1:0]    convIdx;
  logic          convDone;
  logic          startHit;
  logic [SW-1:0] selLine;

  assign convDone = active && busy && eocValid;
  assign startHit = active && !busy && (perCnt < PER_DONE) && (pwmCnt == cmpVal);
  assign selLine  = SW'(NPH) + SW'(perCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      busy    <= 1'b0;
      perCnt  <= '0;
      convIdx <= '0;
      adcTrig <= 1'b0;
      chanSel <= '0;
    end else begin
      adcTrig <= 1'b0;
      if (ctrlTick) begin
        active  <= 1'b1;
        busy    <= 1'b0;
        perCnt  <= '0;
        convIdx <= '0;
      end else if (convDone) begin
        if (convIdx == 2'd2) begin
          busy   <= 1'b0;
          perCnt <= perCnt + PW'(1);
        end else begin
          convIdx <= convIdx + 2'd1;
          adcTrig <= 1'b1;
          chanSel <= (convIdx == 2'd0) ? selLine : SEL_BUS;
        end
      end else if (startHit) begin
        busy    <= 1'b1;
        convIdx <= '0;
        adcTrig <= 1'b1;
        chanSel <= SW'(perCnt);
      end
    end
  end

  always_comb begin
    strobe.wrEn      = convDone && !ctrlTick;
    strobe.swap      = ctrlTick;
    strobe.swapValid = active && (perCnt == PER_DONE);
    strobe.ovrSet    = ctrlTick && active && (perCnt != PER_DONE);
  end

  // R3: only defined channel codes are ever started
  p_sel_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    adcTrig |-> (int'(chanSel) <= 2*NPH));
  // R4: a trigger never repeats while its conversion is pending
  p_trig_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    adcTrig |=> !adcTrig);
  // R5: silence once the window's periods are used up
  p_quiet_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    (perCnt == PER_DONE && !ctrlTick) |=> !adcTrig);
endmodule

// File: rtl/adc_sched_dpath.sv
module adc_sched_dpath
  import adc_sched_pkg::*;
#(
  parameter int NCH = 7,
  parameter int DW  = 12,
  parameter int SW  = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  schedStrobe_t            strobe,
  input  logic [SW-1:0]           wrIdx,
  input  logic [DW-1:0]           eocData,
  output logic [NCH-1:0][DW-1:0]  outBank,
  output logic                    bankValid,
  output logic                    overrun
);
  logic [NCH-1:0][DW-1:0] workBank;

  for (genvar i = 0; i < NCH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        workBank[i] <= '0;
        outBank[i]  <= '0;
      end else begin
        if (strobe.wrEn && (wrIdx == SW'(i))) workBank[i] <= eocData;
        if (strobe.swap) outBank[i] <= workBank[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankValid <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (strobe.swap)   bankValid <= strobe.swapValid;
      if (strobe.ovrSet) overrun   <= 1'b1;
    end
  end

  // R6: presented bank only moves on a tick
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.swap |=> $stable(outBank));
  // R7: validity only re-evaluated on a tick
  p_valid_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.swap |=> $stable(bankValid));
  // R8: overrun is sticky
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);
  // R9: no write without an accepted result
  p_work_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> $stable(workBank));
endmodule

// File: rtl/adc_trig_sched.sv
module adc_trig_sched
  import adc_sched_pkg::*;
#(
  parameter int NPH = 3,
  parameter int CW  = 16,
  parameter int DW  = 12,
  parameter int NCH = 2*NPH+1,
  parameter int SW  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CW-1:0]     pwmCnt,
  input  logic [CW-1:0]     cmpVal,
  input  logic              ctrlTick,
  input  logic              eocValid,
  input  logic [DW-1:0]     eocData,
  output logic              adcTrig,
  output logic [SW-1:0]     chanSel,
  output logic [NCH*DW-1:0] bankOut,
  output logic              bankValid,
  output logic              overrun
);
  schedStrobe_t           strobe;
  logic [NCH-1:0][DW-1:0] outBank;

  adc_sched_ctrl #(.NPH(NPH), .CW(CW), .SW(SW)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwmCnt(pwmCnt), .cmpVal(cmpVal),
    .ctrlTick(ctrlTick), .eocValid(eocValid),
    .adcTrig(adcTrig), .chanSel(chanSel), .strobe(strobe)
  );

  adc_sched_dpath #(.NCH(NCH), .DW(DW), .SW(SW)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(chanSel),
    .eocData(eocData), .outBank(outBank),
    .bankValid(bankValid), .overrun(overrun)
  );

  assign bankOut = outBank;
endmodule

// File: tb/adc_trig_sched_bench.sv
module adc_trig_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPH = 3;
  localparam int NCH = 7;
  localparam int DW  = 12;
  localparam int LAT = 3;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] pwmCnt = '0;
  logic [15:0] cmpVal = 16'd10;
  logic ctrlTick = 1'b0;
  logic eocValid = 1'b0;
  logic [DW-1:0] eocData = '0;
  logic adcTrig;
  logic [2:0] chanSel;
  logic [NCH*DW-1:0] bankOut;
  logic bankValid, overrun;

  int vectors = 0;
  int errors  = 0;
  int cyc = 0;
  int pwmPeriod = 40;
  int spurEvery = 0;
  bit done = 0;

  // reference state
  int mAct, mBusy, mPer, mConv, mSel, mTrig, mValid, mOvr;
  int mWork[NCH];
  int mOut[NCH];
  int dueQ[$];
  int resultN = 0;

  adc_trig_sched u_adc_trig_sched (
    .clk(clk), .rstN(rstN), .pwmCnt(pwmCnt), .cmpVal(cmpVal),
    .ctrlTick(ctrlTick), .eocValid(eocValid), .eocData(eocData),
    .adcTrig(adcTrig), .chanSel(chanSel), .bankOut(bankOut),
    .bankValid(bankValid), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // behavioural model of the requirements
  always @(posedge clk) begin
    if (!rstN) begin
      mAct = 0; mBusy = 0; mPer = 0; mConv = 0; mSel = 0; mTrig = 0;
      mValid = 0; mOvr = 0;
      foreach (mWork[i]) begin mWork[i] = 0; mOut[i] = 0; end
    end else begin
      mTrig = 0;
      if (ctrlTick) begin
        if (mAct != 0 && mPer == NPH) mValid = 1;
        else mValid = 0;
        if (mAct != 0 && mPer != NPH) mOvr = 1;
        foreach (mWork[i]) mOut[i] = mWork[i];
        mAct = 1; mPer = 0; mBusy = 0; mConv = 0;
      end else if (mAct != 0 && mBusy != 0 && eocValid) begin
        mWork[mSel] = eocData;
        if (mConv == 2) begin
          mBusy = 0; mPer++;
        end else begin
          mConv++;
          mSel = (mConv == 1) ? NPH + mPer : 2*NPH;
          mTrig = 1;
        end
      end else if (mAct != 0 && mBusy == 0 && mPer < NPH && pwmCnt == cmpVal) begin
        mBusy = 1; mConv = 0; mSel = mPer; mTrig = 1;
      end
    end
  end

  // stimulus-side drivers and comparison, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rstN) begin
        check(mPer == NPH ? "R5" : "R2/R4 trigger", int'(adcTrig), mTrig);
        if (mTrig != 0) check("R3 channel", int'(chanSel), mSel);
        check("R7 valid", int'(bankValid), mValid);
        check("R8 overrun", int'(overrun), mOvr);
        for (int i = 0; i < NCH; i++)
          check("R6 bank", int'(bankOut[i*DW +: DW]), mOut[i]);
      end
      // ADC responder
      eocValid = 1'b0;
      if (adcTrig) dueQ.push_back(cyc + LAT);
      if (dueQ.size() > 0 && dueQ[0] == cyc) begin
        void'(dueQ.pop_front());
        eocValid = 1'b1;
        eocData = DW'((resultN * 53 + int'(chanSel) * 7) % 2048);
        resultN++;
      end else if (spurEvery > 0 && dueQ.size() == 0 && mBusy == 0 && (cyc % spurEvery) == 0) begin
        eocValid = 1'b1;           // stray strobe, R9
        eocData = 12'hABC;
      end
      pwmCnt = (int'(pwmCnt) + 1 >= pwmPeriod) ? '0 : pwmCnt + 16'd1;
    end
  end

  task automatic tick_after(input int gap);
    repeat (gap - 1) @(negedge clk);
    #1 ctrlTick = 1'b1;
    @(negedge clk);
    #1 ctrlTick = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 trig", int'(adcTrig), 0);
    check("R1 valid", int'(bankValid), 0);
    check("R1 overrun", int'(overrun), 0);
    check("R1 bank", (bankOut == '0) ? 1 : 0, 1);
    #1 rstN = 1'b1;
    // full windows
    for (int k = 0; k < 6; k++) tick_after(170);
    check("R7 full window valid", int'(bankValid), 1);
    check("R8 no overrun yet", int'(overrun), 0);
    // windows cut short
    for (int k = 0; k < 3; k++) tick_after(90 + k);
    check("R8 overrun raised", int'(overrun), 1);
    check("R7 cut window invalid", int'(bankValid), 0);
    // new compare point, faster carrier, stray strobes, odd gaps
    cmpVal = 16'd27; pwmPeriod = 33; spurEvery = 7;
    for (int k = 0; k < 8; k++) tick_after(130 + 3*k);
    check("R8 overrun sticky", int'(overrun), 1);
    check("R7 valid again", int'(bankValid), 1);
    for (int i = 0; i < NCH; i++)
      check("R9 stray data absent", (bankOut[i*DW +: DW] == 12'hABC) ? 1 : 0, 0);
    repeat (50) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule